// File: doc/BRIEF.md
# I2C Channel-Select Control Register

This block is an I2C target that owns a single control byte and turns it into enable signals for four downstream bus channels. The block samples SCL and SDA with the system clock through a short synchronizer. It finds START, repeated START and STOP conditions, and it matches a 7-bit address. That address is a fixed upper nibble (binary 1110) followed by three strap inputs. After a matching write address, the block acknowledges every data byte and keeps the last one as the new selection. After a matching read address, it returns the selection currently in force.

A newly written selection is held pending and reaches the channel-enable outputs only when a STOP condition appears on the bus. A repeated START does not apply it. This way a channel is never connected partway through a transfer. Any mix of the four channels may be enabled, from none to all. SDA is driven open-drain through an output-enable. While that enable is high, the line is pulled low. An active-low reset clears the selection, so no channel is enabled.

Top module: `i2c_chansel_reg`

## Requirements
- R1: The block acknowledges (pulls SDA low in the ninth clock) only the 7-bit address {1110, strap[2:0]}, sent MSB first with the R/W bit last. Any other address gets no acknowledge, and data written after it leaves the channel enables unchanged.
- R2: After a matching write address, each data byte (MSB first) is acknowledged and is taken as the pending selection.
- R3: When several data bytes are written in one transaction, the last one is the selection that applies.
- R4: Bit n of the data byte (n = 0..3) enables channel n (chan_en[n] = 1). Bits 7..4 are ignored. All 16 combinations are accepted.
- R5: A written selection does not change chan_en when its byte is acknowledged. It appears on chan_en a few system clocks after the next STOP.
- R6: A repeated START does not apply a pending selection. The pending value is kept and applied at the next STOP.
- R7: A read returns the byte {0000, chan_en[3:0]}, MSB first. This is the applied selection, not a pending one. Each byte the master acknowledges is followed by the same byte again.
- R8: When the master does not acknowledge a read byte, the block releases SDA and stays off the bus until the next START.
- R9: While rst_n is low, and right after it rises, chan_en is 0000, sda_oe is 0, and a read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| strap | input | 3 | Low three address bits |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| chan_en | output | 4 | Applied channel enables, bit n = channel n |

## Verification
The address phase is swept over all 128 addresses, which shows that only the one strap-selected address draws an acknowledge. A second strap setting confirms that the strap bits really take part in the match. All sixteen low-nibble selections are written with changing upper nibbles. Each one is checked against chan_en before and after STOP and again by readback, which separates the STOP commit from the acknowledge instant and the stored nibble from the ignored one. Multi-byte writes, a write followed by a repeated-START read, and a NACKed read followed by extra clocks cover three things: last-byte-wins, the pending-versus-applied difference, and bus release.

// File: rtl/chansel_pkg.sv
package chansel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_t;

  // 7-bit target address: fixed upper nibble then strap bits
  function automatic logic [6:0] make_addr(input logic [3:0] hi, input logic [2:0] straps);
    return {hi, straps};
  endfunction

  // status byte: applied channel enables in the low nibble, zeros above
  function automatic logic [7:0] status_byte(input logic [3:0] sel);
    return {4'b0000, sel};
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_q & scl_s & sda_q & ~sda_s;
  assign stop_evt  = scl_q & scl_s & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import chansel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [6:0] dev_addr,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic       wr_evt,
  output logic [7:0] wr_data
);
  localparam int CNT_W = 4;

  tgt_state_t        state;
  logic [7:0]        rx_sh;
  logic [7:0]        tx_sh;
  logic [CNT_W-1:0]  bit_cnt;
  logic              rd_mode;
  logic              m_ack;
  logic              byte_done;

  assign byte_done = scl_fall && (bit_cnt == CNT_W'(8));
  assign wr_evt    = (state == ST_WDATA) && byte_done;
  assign wr_data   = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rx_sh   <= '0;
      tx_sh   <= '0;
      bit_cnt <= '0;
      rd_mode <= 1'b0;
      m_ack   <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_evt) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_evt) begin
      state   <= ST_IDLE;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: sda_oe <= 1'b0;
        ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            if (state == ST_WDATA) begin
              state  <= ST_WACK;
              sda_oe <= 1'b1;
            end else if (rx_sh[7:1] == dev_addr) begin
              state   <= ST_AACK;
              rd_mode <= rx_sh[0];
              sda_oe  <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rd_mode) begin
              state  <= ST_RDATA;
              tx_sh  <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end else begin
              state  <= ST_WDATA;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            state   <= ST_WDATA;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            state  <= ST_RACK;
            sda_oe <= 1'b0;
          end else if (scl_fall) begin
            tx_sh  <= {tx_sh[6:0], 1'b0};
            sda_oe <= ~tx_sh[6];
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_s;
          end else if (scl_fall) begin
            bit_cnt <= '0;
            if (m_ack) begin
              state  <= ST_RDATA;
              tx_sh  <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R2
  oe_assert_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && sda_oe) |-> !scl_s);

  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

endmodule

// File: rtl/chansel_store.sv
module chansel_store #(
  parameter int CHANNELS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_evt,
  input  logic [CHANNELS-1:0] wr_sel,
  input  logic                stop_evt,
  output logic [CHANNELS-1:0] active
);
  logic [CHANNELS-1:0] pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      active  <= '0;
    end else begin
      if (wr_evt)   pending <= wr_sel;
      if (stop_evt) active  <= pending;
    end
  end

  // R5
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_evt |=> $stable(active));

  // R6
  stop_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (active == $past(pending)));

  // R3
  last_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> (pending == $past(wr_sel)));

endmodule

// File: rtl/i2c_chansel_reg.sv
module i2c_chansel_reg
  import chansel_pkg::*;
#(
  parameter logic [3:0] ADDR_HI     = 4'b1110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] strap,
  output logic       sda_oe,
  output logic [3:0] chan_en
);
  localparam int CHANNELS = 4;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic wr_evt;
  logic [7:0] wr_data;
  logic [CHANNELS-1:0] active;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_target_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .dev_addr(make_addr(ADDR_HI, strap)),
    .rd_byte(status_byte(active)),
    .sda_oe(sda_oe), .wr_evt(wr_evt), .wr_data(wr_data)
  );

  chansel_store #(.CHANNELS(CHANNELS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt),
    .wr_sel(wr_data[CHANNELS-1:0]), .stop_evt(stop_evt), .active(active)
  );

  assign chan_en = active;

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (chan_en == '0));

endmodule

// File: tb/tb_i2c_chansel_reg.sv
module tb_i2c_chansel_reg;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  logic [3:0] chan_en;
  wire sda_line = msda & ~sda_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_chansel_reg dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .strap(strap), .sda_oe(sda_oe), .chan_en(chan_en)
  );

  function automatic logic [6:0] exp_addr(input logic [2:0] s);
    return 7'd112 + 7'(s);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    msda = 1'b1; qwait();
    scl = 1'b1; qwait();
    msda = 1'b0; qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    msda = 1'b0; qwait();
    scl = 1'b1; qwait();
    msda = 1'b1; qwait();
    qwait();
  endtask

  task automatic put_bit(input logic b);
    msda = b; qwait();
    scl = 1'b1; qwait(); qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic get_bit(output logic b);
    msda = 1'b1; qwait();
    scl = 1'b1; qwait();
    b = sda_line; qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic put_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic read_status(output logic [7:0] d, output logic acked);
    bus_start();
    put_byte({exp_addr(strap), 1'b1}, acked);
    get_byte(d, 1'b0);
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic ack;
    logic [7:0] rd;
    logic [3:0] applied;
    logic [7:0] d;
    logic b;

    repeat (5) @(negedge clk);
    // R9: state during reset
    chk("R9 chan_en in reset", 8'(chan_en), 8'h00);
    chk("R9 sda_oe in reset", 8'(sda_oe), 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 chan_en after reset", 8'(chan_en), 8'h00);
    read_status(rd, ack);
    chk("R9 read after reset", rd, 8'h00);
    applied = 4'h0;

    // R1: sweep all addresses with strap 101
    for (int a = 0; a < 128; a++) begin
      bus_start();
      put_byte({7'(a), 1'b0}, ack);
      bus_stop();
      chk($sformatf("R1 ack for addr %0h", a), 8'(ack), 8'(7'(a) == exp_addr(strap)));
    end

    // R1: data after a foreign address is ignored
    bus_start();
    put_byte({7'h70, 1'b0}, ack);
    put_byte(8'h0F, ack);
    chk("R1 foreign data no ack", 8'(ack), 8'h00);
    bus_stop();
    chk("R1 foreign write ignored", 8'(chan_en), 8'(applied));

    // R2 R4 R5 R7: all low-nibble selections, varied upper nibble
    for (int v = 0; v < 16; v++) begin
      d = {4'(v * 7 + 3), 4'(v)};
      bus_start();
      put_byte({exp_addr(strap), 1'b0}, ack);
      put_byte(d, ack);
      chk($sformatf("R2 data ack v=%0d", v), 8'(ack), 8'h01);
      chk($sformatf("R5 held before stop v=%0d", v), 8'(chan_en), 8'(applied));
      bus_stop();
      applied = 4'(v);
      chk($sformatf("R4 chan_en v=%0d", v), 8'(chan_en), 8'(v));
      read_status(rd, ack);
      chk($sformatf("R7 readback v=%0d", v), rd, {4'h0, 4'(v)});
    end

    // R3: several bytes, last wins
    bus_start();
    put_byte({exp_addr(strap), 1'b0}, ack);
    put_byte(8'h09, ack);
    put_byte(8'hA3, ack);
    put_byte(8'h56, ack);
    chk("R3 last byte ack", 8'(ack), 8'h01);
    bus_stop();
    applied = 4'h6;
    chk("R3 last byte wins", 8'(chan_en), 8'h06);

    // R6 R7: write, repeated START read, then STOP
    bus_start();
    put_byte({exp_addr(strap), 1'b0}, ack);
    put_byte(8'h0C, ack);
    bus_start();
    chk("R6 no apply on repeated start", 8'(chan_en), 8'(applied));
    put_byte({exp_addr(strap), 1'b1}, ack);
    chk("R6 read address ack", 8'(ack), 8'h01);
    get_byte(rd, 1'b1);
    chk("R7 read returns applied not pending", rd, 8'h06);
    get_byte(rd, 1'b0);
    chk("R7 second acked byte repeats", rd, 8'h06);
    chk("R6 still old before stop", 8'(chan_en), 8'h06);
    bus_stop();
    applied = 4'hC;
    chk("R6 pending applied at stop", 8'(chan_en), 8'h0C);

    // R8: after master NACK, SDA released until next START
    bus_start();
    put_byte({exp_addr(strap), 1'b1}, ack);
    get_byte(rd, 1'b0);
    chk("R8 read data", rd, 8'h0C);
    d = 8'h00;
    for (int i = 0; i < 8; i++) begin
      get_bit(b);
      d[i] = b;
    end
    chk("R8 released after nack", d, 8'hFF);
    get_bit(b);
    chk("R8 released ninth bit", 8'(b), 8'h01);
    bus_stop();
    chk("R8 no change from read", 8'(chan_en), 8'h0C);

    // R1: new strap value
    strap = 3'b010;
    repeat (4) @(negedge clk);
    bus_start();
    put_byte({7'h72, 1'b0}, ack);
    put_byte(8'h03, ack);
    bus_stop();
    chk("R1 strap 010 ack", 8'(ack), 8'h01);
    chk("R1 strap 010 write", 8'(chan_en), 8'h03);
    bus_start();
    put_byte({7'h75, 1'b0}, ack);
    bus_stop();
    chk("R1 old strap addr rejected", 8'(ack), 8'h00);

    // R9: reset clears the selection
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset clears", 8'(chan_en), 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_status(rd, ack);
    chk("R9 read after second reset", rd, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule